// File: doc/BRIEF.md
# Cascadable synchronous presettable binary counter

This block is one stage of a synchronous up-counter, `WIDTH` bits wide (four by default). Every state change is made at the rising clock edge. Three actions are possible: a clear to zero, a parallel preset from the data inputs, and a count step. A clear wins over a preset. A preset wins over counting. Counting requires two separate enables to both be high.

A terminal-count output is formed directly from the stored state and the chain enable. It rises in the same cycle that the chain enable rises, so no clock edge is needed. It ignores the count enable.

Wider counters are built by chaining stages. Every stage shares one count enable and the clear and preset controls. Each stage's chain enable is driven by the terminal-count output of the stage below it. The result is one wide synchronous counter that needs no look-ahead gate between stages.

Top module: `pcnt_stage`

## Requirements
- R1: The state `q` changes only at a rising edge of `clk`. Input changes made between edges leave `q` unchanged until the next edge.
- R2: If `clear_n` is 0 at an edge, `q` becomes all zeros, whatever the values of `load_n`, `en_count` and `en_chain`.
- R3: If `clear_n` is 1 and `load_n` is 0 at an edge, `q` takes the value of `d`, whatever the two enables are.
- R4: If `clear_n`, `load_n`, `en_count` and `en_chain` are all 1 at an edge, `q` increases by one.
- R5: If `clear_n` and `load_n` are 1 and either enable is 0 at an edge, `q` keeps its value.
- R6: `carry_out` is 1 exactly when `en_chain` is 1 and `q` is all ones. It follows `en_chain` within the same cycle and does not depend on `en_count`.
- R7: Bit 0 of `q` is the least significant bit. The count is plain binary and wraps from all ones to all zeros.
- R8: Two stages form an 8-bit counter when they share `en_count`, `clear_n` and `load_n` and the upper stage's `en_chain` is driven by the lower stage's `carry_out`. The count crosses the stage boundary correctly. A preset or clear applied while the chain carry is high takes priority over the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| clear_n | input | 1 | Synchronous clear to zero, active low, highest priority |
| load_n | input | 1 | Synchronous parallel preset from `d`, active low |
| en_count | input | 1 | Count enable, shared across a chain |
| en_chain | input | 1 | Count enable that also gates `carry_out`; driven by the lower stage in a chain |
| d | input | WIDTH | Preset value |
| q | output | WIDTH | Counter state, bit 0 least significant |
| carry_out | output | 1 | Terminal count: `en_chain` and `q` all ones |

## Verification
The bench checks the priority order by asserting clear together with preset and both enables. A design with the wrong order would load or count instead of returning to zero. It toggles `en_chain` mid-cycle while the state is all ones, with `en_count` low. A registered carry would lag by one cycle here, and a carry gated by the count enable would stay low. An 8-bit chain is run against a reference count through the 0x0F-to-0x10 and 0xFF-to-0x00 boundaries, with a preset and a clear applied while the chain carry is high. A design with a misrouted carry would advance the upper nibble on the wrong cycle or let the count override the preset.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ZERO = 2'd1,
    OP_LOAD = 2'd2,
    OP_INC  = 2'd3
  } pcnt_op_e;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic     clear_n,
  input  logic     load_n,
  input  logic     en_count,
  input  logic     en_chain,
  output pcnt_op_e op
);
  // Fixed priority: clear, then preset, then count (needs both enables).
  always_comb begin
    if (!clear_n)                  op = OP_ZERO;
    else if (!load_n)              op = OP_LOAD;
    else if (en_count && en_chain) op = OP_INC;
    else                           op = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  pcnt_op_e         op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] inc;
  logic [WIDTH:0]   rip;

  // Bitwise ripple incrementer; bit i toggles when all lower bits are ones.
  assign rip[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_inc
    assign inc[i]   = cur[i] ^ rip[i];
    assign rip[i+1] = cur[i] & rip[i];
  end

  always_comb begin
    unique case (op)
      OP_ZERO: nxt = '0;
      OP_LOAD: nxt = d;
      OP_INC:  nxt = inc;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/pcnt_term.sv
module pcnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_chain,
  output logic             carry_out
);
  assign carry_out = en_chain & (&cur);
endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             en_count,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  pcnt_op_e         op;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  pcnt_ctrl u_ctrl (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .en_count (en_count),
    .en_chain (en_chain),
    .op       (op)
  );

  pcnt_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (state_q),
    .d   (d),
    .nxt (state_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  pcnt_term #(.WIDTH(WIDTH)) u_term (
    .cur       (state_q),
    .en_chain  (en_chain),
    .carry_out (carry_out)
  );

  assign q = state_q;
endmodule

// File: rtl/pcnt_stage_chk.sv
module pcnt_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             en_count,
  input logic             en_chain,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!primed)
    !clear_n |=> (q == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (!primed)
    (clear_n && !load_n) |=> (q == $past(d)));

  p_count_r4: assert property (@(posedge clk) disable iff (!primed)
    (clear_n && load_n && en_count && en_chain && !$isunknown(q))
    |=> (q == WIDTH'($past(q) + 1'b1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!primed)
    (clear_n && load_n && !(en_count && en_chain)) |=> $stable(q));

  p_carry_r6: assert property (@(posedge clk) disable iff (!primed)
    carry_out |-> (en_chain && (q == '1)));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!primed)
    (clear_n && load_n && en_count && en_chain && q == '1) |=> (q == '0));
endmodule

bind pcnt_stage pcnt_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .load_n    (load_n),
  .en_count  (en_count),
  .en_chain  (en_chain),
  .d         (d),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/pcnt_stage_tb.sv
`timescale 1ns/1ps
module pcnt_stage_tb;
  logic       clk = 1'b0;
  logic       clr_n, ld_n, pe, te;
  logic [3:0] d, q;
  logic       co;
  // two-stage chain
  logic       c_clr_n, c_ld_n, c_pe, c_te;
  logic [7:0] c_d, c_q;
  logic       c_lo_co, c_hi_co;
  logic [7:0] ref_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcnt_stage #(.WIDTH(4)) u_dut (
    .clk(clk), .clear_n(clr_n), .load_n(ld_n), .en_count(pe), .en_chain(te),
    .d(d), .q(q), .carry_out(co));

  pcnt_stage #(.WIDTH(4)) u_lo (
    .clk(clk), .clear_n(c_clr_n), .load_n(c_ld_n), .en_count(c_pe), .en_chain(c_te),
    .d(c_d[3:0]), .q(c_q[3:0]), .carry_out(c_lo_co));

  pcnt_stage #(.WIDTH(4)) u_hi (
    .clk(clk), .clear_n(c_clr_n), .load_n(c_ld_n), .en_count(c_pe), .en_chain(c_lo_co),
    .d(c_d[7:4]), .q(c_q[7:4]), .carry_out(c_hi_co));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // R2: clear dominates preset and both enables
  task automatic t_clear;
    clr_n = 0; ld_n = 0; pe = 1; te = 1; d = 4'hA;
    tick;
    chk("R2 clear over load and count", q, 4'h0);
    clr_n = 1; ld_n = 0; d = 4'h9; tick;
    clr_n = 0; ld_n = 1; tick;
    chk("R2 clear from nonzero", q, 4'h0);
  endtask

  // R3: preset regardless of enables
  task automatic t_load;
    clr_n = 1; ld_n = 0; pe = 0; te = 0; d = 4'h6;
    tick;
    chk("R3 load with enables low", q, 4'h6);
    pe = 1; te = 1; d = 4'hC;
    tick;
    chk("R3 load over count", q, 4'hC);
  endtask

  // R4, R7: count and wrap
  task automatic t_count;
    clr_n = 1; ld_n = 0; d = 4'hD; tick;
    ld_n = 1; pe = 1; te = 1;
    tick; chk("R4 increment", q, 4'hE);
    tick; chk("R4 increment", q, 4'hF);
    tick; chk("R7 wrap to zero", q, 4'h0);
    tick; chk("R7 lsb first count", q, 4'h1);
  endtask

  // R5: hold when either enable low
  task automatic t_hold;
    clr_n = 1; ld_n = 0; d = 4'h5; tick;
    ld_n = 1; pe = 0; te = 1; tick;
    chk("R5 hold count enable low", q, 4'h5);
    pe = 1; te = 0; tick;
    chk("R5 hold chain enable low", q, 4'h5);
    pe = 0; te = 0; tick;
    chk("R5 hold both low", q, 4'h5);
  endtask

  // R6: combinational terminal count, independent of en_count
  task automatic t_carry;
    clr_n = 1; ld_n = 0; d = 4'hF; pe = 0; te = 0; tick;
    ld_n = 1;
    #0.5 chk("R6 carry low with chain low", co, 1'b0);
    te = 1;
    #0.5 chk("R6 carry follows chain enable same cycle", co, 1'b1);
    te = 0;
    #0.5 chk("R6 carry drops with chain enable", co, 1'b0);
    te = 1; tick;
    chk("R6 carry with count enable low", co, 1'b1);
    ld_n = 0; d = 4'hE; tick;
    chk("R6 carry low below terminal", co, 1'b0);
  endtask

  // R1: mid-cycle input changes do not move the state
  task automatic t_edge;
    clr_n = 1; ld_n = 0; d = 4'h3; pe = 0; te = 0; tick;
    ld_n = 1;
    #0.5 clr_n = 0;
    #0.5 clr_n = 1; ld_n = 0; d = 4'h8;
    #0.5 ld_n = 1; pe = 1; te = 1;
    #0.5 pe = 0;
    chk("R1 no change between edges", q, 4'h3);
    tick;
    chk("R1 hold at edge with count enable low", q, 4'h3);
  endtask

  task automatic c_step;
    if (!c_clr_n)       ref_q = 8'h00;
    else if (!c_ld_n)   ref_q = c_d;
    else if (c_pe && c_te) ref_q = ref_q + 8'h01;
    tick;
    chk("R8 chain state", c_q, ref_q);
    chk("R8 chain carry", c_hi_co, (c_te && ref_q == 8'hFF));
  endtask

  // R8: two-stage chain against a reference count
  task automatic t_cascade;
    c_clr_n = 0; c_ld_n = 1; c_pe = 1; c_te = 1; c_d = 8'h00;
    c_step;
    c_clr_n = 1; c_ld_n = 0; c_d = 8'h0E; c_step;
    c_ld_n = 1; c_step; c_step;
    chk("R8 nibble boundary", c_q, 8'h10);
    c_ld_n = 0; c_d = 8'hFE; c_step;
    c_ld_n = 1; c_step;
    chk("R8 carry at all ones", c_hi_co, 1'b1);
    c_ld_n = 0; c_d = 8'h3C; c_step;
    chk("R8 load during carry", c_q, 8'h3C);
    c_d = 8'hFF; c_step;
    c_ld_n = 1; c_clr_n = 0; c_step;
    chk("R8 clear during carry", c_q, 8'h00);
    c_clr_n = 1; c_ld_n = 0; c_d = 8'hF0; c_step;
    c_ld_n = 1;
    for (int i = 0; i < 300; i++) begin
      c_pe = (i % 7) != 3;
      c_te = (i % 11) != 5;
      c_ld_n = !((i % 97) == 96);
      c_d = 8'(i * 37);
      c_clr_n = (i != 250);
      c_step;
    end
  endtask

  initial begin
    clr_n = 0; ld_n = 1; pe = 0; te = 0; d = '0;
    c_clr_n = 0; c_ld_n = 1; c_pe = 0; c_te = 0; c_d = '0; ref_q = '0;
    tick;
    chk("R2 reset state", q, 4'h0);
    t_clear;
    t_load;
    t_count;
    t_hold;
    t_carry;
    t_edge;
    t_cascade;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule